// File: doc/BRIEF.md
# Software Trap Entry Sequencer

This block carries out the exception entry that follows a software trap instruction. When `start_i` arrives with a 4-bit trap number, the block latches the caller's status word, program counter and stack pointer. It then saves a three-word frame on the supervisor stack and loads the handler address from the vector table. All of this goes through one 16-bit memory port with a request/acknowledge handshake.

The frame is the 32-bit program counter followed by the status word as it stood before the trap. The handler address is held as two 16-bit words at byte address `(32 + n) * 4`, with the high word at the lower address. When the sequence ends, the block presents three results for one cycle, marked by `done_o`: the lowered stack pointer, the status word with supervisor mode forced on, and the new program counter. These results stay valid until the next trap completes.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mem_req_o` are low, and `sr_o`, `sp_o` and `pc_o` are zero.
- R2: The handler address is read as two word reads (`mem_we_o` = 0): the high half from byte address `(32 + n) * 4`, then the low half from that address + 2. `pc_o` is the high half concatenated with the low half.
- R3: The first write stores `pc[31:16]` at `sp - 4`. The second write stores `pc[15:0]` at `sp - 2`.
- R4: The third write stores the status word sampled at start, unmodified, at `sp - 6`.
- R5: `sr_o` equals the sampled status word with bit 13 (supervisor) set, whether or not that bit was already set.
- R6: `sp_o` equals the sampled stack pointer minus 6.
- R7: Each trap makes exactly five memory accesses, in this order: PC high, PC low, status, vector high, vector low. Each request holds its address, direction and data steady until it is acknowledged. The next access begins only after that acknowledge.
- R8: `busy_o` rises in the cycle after start is accepted and stays high through the single cycle in which `done_o` is high. The block then returns to idle.
- R9: A `start_i` pulse that arrives while `busy_o` is high has no effect on the accesses or results of the trap in progress.
- R10: The trap number, status word, program counter and stack pointer are sampled only on the accepted start edge. Later changes to those inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a trap entry (accepted only when idle) |
| trap_num_i | input | 4 | Trap number n from the instruction |
| sr_i | input | 16 | Current status word |
| pc_i | input | 32 | Return program counter |
| sp_i | input | 32 | Current supervisor stack pointer |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion strobe |
| sr_o | output | 16 | Status word with supervisor bit forced |
| sp_o | output | 32 | Stack pointer after the frame is pushed |
| pc_o | output | 32 | Handler address read from the vector table |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Access complete (read data valid) |
| mem_rdata_i | input | 16 | Read data |

## Verification
`busy_o` and the first request appear one cycle after the accepted start edge. Each later request appears in the cycle after the previous acknowledge. `done_o` and the three results appear together in the cycle after the fifth acknowledge, and `done_o` falls one cycle later. The bench's memory model acknowledges after 0, 1 or 2 wait cycles and logs every completed access at the falling edge. The bench samples `busy_o`, `done_o` and the results at falling edges: once right after start, at the cycle in which `done_o` is first seen, and once more a cycle later. It then compares the access log entry by entry against the frame and vector addresses it computes itself.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PC_HI,
    ST_PUSH_PC_LO,
    ST_PUSH_SR,
    ST_FETCH_HI,
    ST_FETCH_LO,
    ST_DONE
  } trap_state_e;
endpackage

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
  import trap_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        ack_i,
  output trap_state_e state_o,
  output logic        launch_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        req_o,
  output logic        we_o
);
  trap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (start_i) state_d = ST_PUSH_PC_HI;
      ST_PUSH_PC_HI: if (ack_i) state_d = ST_PUSH_PC_LO;
      ST_PUSH_PC_LO: if (ack_i) state_d = ST_PUSH_SR;
      ST_PUSH_SR:    if (ack_i) state_d = ST_FETCH_HI;
      ST_FETCH_HI:   if (ack_i) state_d = ST_FETCH_LO;
      ST_FETCH_LO:   if (ack_i) state_d = ST_DONE;
      ST_DONE:       state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o  = state_q;
  assign launch_o = (state_q == ST_IDLE) && start_i;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_DONE);
  assign we_o     = (state_q == ST_PUSH_PC_HI) || (state_q == ST_PUSH_PC_LO) ||
                    (state_q == ST_PUSH_SR);
  assign req_o    = we_o || (state_q == ST_FETCH_HI) || (state_q == ST_FETCH_LO);
endmodule

// File: rtl/trap_addr_gen.sv
module trap_addr_gen
  import trap_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 16,
  parameter int unsigned PCW      = 32,
  parameter int unsigned TRAP_W   = 4,
  parameter int unsigned VEC_BASE = 32
) (
  input  trap_state_e       state_i,
  input  logic [AW-1:0]     sp_i,
  input  logic [TRAP_W-1:0] num_i,
  output logic [AW-1:0]     addr_o,
  output logic [AW-1:0]     sp_final_o
);
  localparam int unsigned WORD_BYTES  = DW / 8;
  localparam int unsigned PC_BYTES    = PCW / 8;
  localparam int unsigned FRAME_BYTES = PC_BYTES + WORD_BYTES;
  localparam int unsigned VEC_SHIFT   = $clog2(PC_BYTES);

  logic [AW-1:0] pc_slot;
  logic [AW-1:0] vec_addr;

  assign pc_slot    = sp_i - AW'(PC_BYTES);
  assign sp_final_o = sp_i - AW'(FRAME_BYTES);
  assign vec_addr   = (AW'(VEC_BASE) + AW'(num_i)) << VEC_SHIFT;

  always_comb begin
    unique case (state_i)
      ST_PUSH_PC_HI: addr_o = pc_slot;
      ST_PUSH_PC_LO: addr_o = pc_slot + AW'(WORD_BYTES);
      ST_PUSH_SR:    addr_o = sp_final_o;
      ST_FETCH_HI:   addr_o = vec_addr;
      ST_FETCH_LO:   addr_o = vec_addr + AW'(WORD_BYTES);
      default:       addr_o = '0;
    endcase
  end
endmodule

// File: rtl/trap_data_path.sv
module trap_data_path
  import trap_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 16,
  parameter int unsigned PCW     = 32,
  parameter int unsigned TRAP_W  = 4,
  parameter int unsigned SUP_BIT = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              ack_i,
  input  trap_state_e       state_i,
  input  logic [DW-1:0]     sr_i,
  input  logic [PCW-1:0]    pc_i,
  input  logic [AW-1:0]     sp_i,
  input  logic [TRAP_W-1:0] num_i,
  input  logic [DW-1:0]     rdata_i,
  input  logic [AW-1:0]     sp_final_i,
  output logic [AW-1:0]     sp_cap_o,
  output logic [TRAP_W-1:0] num_cap_o,
  output logic [DW-1:0]     wdata_o,
  output logic [DW-1:0]     sr_o,
  output logic [AW-1:0]     sp_o,
  output logic [PCW-1:0]    pc_o
);
  localparam logic [DW-1:0] SUP_MASK = {{(DW-1){1'b0}}, 1'b1} << SUP_BIT;

  logic [DW-1:0]     sr_cap_q;
  logic [PCW-1:0]    pc_cap_q;
  logic [AW-1:0]     sp_cap_q;
  logic [TRAP_W-1:0] num_q;
  logic [DW-1:0]     vec_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_cap_q <= '0;
      pc_cap_q <= '0;
      sp_cap_q <= '0;
      num_q    <= '0;
    end else if (launch_i) begin
      sr_cap_q <= sr_i;
      pc_cap_q <= pc_i;
      sp_cap_q <= sp_i;
      num_q    <= num_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_hi_q <= '0;
      sr_o     <= '0;
      sp_o     <= '0;
      pc_o     <= '0;
    end else if (ack_i) begin
      if (state_i == ST_FETCH_HI) vec_hi_q <= rdata_i;
      if (state_i == ST_FETCH_LO) begin
        pc_o <= PCW'({vec_hi_q, rdata_i});
        sr_o <= sr_cap_q | SUP_MASK;  // status pushed earlier stays unmodified
        sp_o <= sp_final_i;
      end
    end
  end

  always_comb begin
    unique case (state_i)
      ST_PUSH_PC_HI: wdata_o = pc_cap_q[PCW-1 -: DW];
      ST_PUSH_PC_LO: wdata_o = pc_cap_q[DW-1:0];
      ST_PUSH_SR:    wdata_o = sr_cap_q;
      default:       wdata_o = '0;
    endcase
  end

  assign sp_cap_o  = sp_cap_q;
  assign num_cap_o = num_q;
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 16,
  parameter int unsigned PCW      = 32,
  parameter int unsigned TRAP_W   = 4,
  parameter int unsigned VEC_BASE = 32,
  parameter int unsigned SUP_BIT  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TRAP_W-1:0] trap_num_i,
  input  logic [DW-1:0]     sr_i,
  input  logic [PCW-1:0]    pc_i,
  input  logic [AW-1:0]     sp_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DW-1:0]     sr_o,
  output logic [AW-1:0]     sp_o,
  output logic [PCW-1:0]    pc_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DW-1:0]     mem_rdata_i
);
  trap_state_e       state;
  logic              launch;
  logic              ack_q;
  logic [AW-1:0]     sp_cap;
  logic [AW-1:0]     sp_final;
  logic [TRAP_W-1:0] num_cap;

  // acknowledges outside a request are not ours
  assign ack_q = mem_ack_i && mem_req_o;

  trap_seq_fsm i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .ack_i    (ack_q),
    .state_o  (state),
    .launch_o (launch),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .req_o    (mem_req_o),
    .we_o     (mem_we_o)
  );

  trap_addr_gen #(
    .AW(AW), .DW(DW), .PCW(PCW), .TRAP_W(TRAP_W), .VEC_BASE(VEC_BASE)
  ) i_addr (
    .state_i    (state),
    .sp_i       (sp_cap),
    .num_i      (num_cap),
    .addr_o     (mem_addr_o),
    .sp_final_o (sp_final)
  );

  trap_data_path #(
    .AW(AW), .DW(DW), .PCW(PCW), .TRAP_W(TRAP_W), .SUP_BIT(SUP_BIT)
  ) i_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (launch),
    .ack_i      (ack_q),
    .state_i    (state),
    .sr_i       (sr_i),
    .pc_i       (pc_i),
    .sp_i       (sp_i),
    .num_i      (trap_num_i),
    .rdata_i    (mem_rdata_i),
    .sp_final_i (sp_final),
    .sp_cap_o   (sp_cap),
    .num_cap_o  (num_cap),
    .wdata_o    (mem_wdata_o),
    .sr_o       (sr_o),
    .sp_o       (sp_o),
    .pc_o       (pc_o)
  );
endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk #(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 16,
  parameter int unsigned TRAP_W   = 4,
  parameter int unsigned VEC_BASE = 32,
  parameter int unsigned SUP_BIT  = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [TRAP_W-1:0] trap_num_i,
  input logic [DW-1:0]     sr_i,
  input logic [AW-1:0]     sp_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DW-1:0]     sr_o,
  input logic [AW-1:0]     sp_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [AW-1:0]     mem_addr_o,
  input logic [DW-1:0]     mem_wdata_o,
  input logic              mem_ack_i
);
  logic [AW-1:0] chk_sp;
  logic [DW-1:0] chk_sr;
  logic [AW-1:0] chk_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_sp  <= '0;
      chk_sr  <= '0;
      chk_vec <= '0;
    end else if (start_i && !busy_o) begin
      chk_sp  <= sp_i;
      chk_sr  <= sr_i;
      chk_vec <= (AW'(VEC_BASE) + AW'(trap_num_i)) * AW'(4);
    end
  end

  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wdata_o));
  assert_req_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  assert_done_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o && !mem_req_o);
  assert_busy_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);
  assert_sp_final_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sp_o == chk_sp - AW'(6));
  assert_sr_sup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sr_o == (chk_sr | (DW'(1) << SUP_BIT)));
  assert_fetch_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> mem_addr_o == chk_vec || mem_addr_o == chk_vec + AW'(2));
  assert_push_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> (chk_sp - mem_addr_o == AW'(2)) ||
                              (chk_sp - mem_addr_o == AW'(4)) ||
                              (chk_sp - mem_addr_o == AW'(6)));
  assert_sr_push_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_addr_o == chk_sp - AW'(6) |-> mem_wdata_o == chk_sr);
endmodule

bind trap_entry_seq trap_entry_seq_chk #(
  .AW(AW), .DW(DW), .TRAP_W(TRAP_W), .VEC_BASE(VEC_BASE), .SUP_BIT(SUP_BIT)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .trap_num_i  (trap_num_i),
  .sr_i        (sr_i),
  .sp_i        (sp_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .sr_o        (sr_o),
  .sp_o        (sp_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/test_trap_entry_seq.sv
module test_trap_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  num = '0;
  logic [15:0] sr_in = '0;
  logic [31:0] pc_in = '0;
  logic [31:0] sp_in = '0;
  logic        busy, done, req, we, ack;
  logic [15:0] sr_out, wdata, rdata;
  logic [31:0] sp_out, pc_out, addr;

  int total = 0;
  int bad = 0;
  int lat = 0;
  int n_log = 0;
  int cnt = 0;
  logic [31:0] log_addr [8];
  logic        log_we   [8];
  logic [15:0] log_wd   [8];
  logic [15:0] mem [256];

  always #2 clk = ~clk;

  trap_entry_seq i_trap_entry_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .trap_num_i(num),
    .sr_i(sr_in), .pc_i(pc_in), .sp_i(sp_in),
    .busy_o(busy), .done_o(done), .sr_o(sr_out), .sp_o(sp_out), .pc_o(pc_out),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_ack_i(ack), .mem_rdata_i(rdata)
  );

  // memory model: acknowledges after lat wait cycles, logs completed accesses
  initial begin
    ack = 1'b0;
    rdata = '0;
    forever begin
      @(negedge clk);
      if (ack) begin
        ack = 1'b0;
        cnt = 0;
      end else if (req) begin
        if (cnt >= lat) begin
          ack = 1'b1;
          if (n_log < 8) begin
            log_addr[n_log] = addr;
            log_we[n_log]   = we;
            log_wd[n_log]   = wdata;
          end
          n_log++;
          if (we) mem[addr[8:1]] = wdata;
          else    rdata = mem[addr[8:1]];
        end else cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] vec_word(input int n);
    return {16'hC0DE ^ 16'(n), 16'h1000 + 16'(n * 16)};
  endfunction

  task automatic run_trap(input int n, input logic [15:0] s, input logic [31:0] sp,
                          input logic [31:0] pc, input bit inject);
    logic [31:0] va;
    int waited;
    va = 32'((32 + n) * 4);
    for (int k = 0; k < 16; k++) begin
      mem[(32 + k) * 2]     = vec_word(k)[31:16];
      mem[(32 + k) * 2 + 1] = vec_word(k)[15:0];
    end
    n_log = 0;
    @(negedge clk);
    start = 1'b1; num = 4'(n); sr_in = s; sp_in = sp; pc_in = pc;
    @(negedge clk);
    // R10: scramble inputs once start is accepted
    start = 1'b0; num = ~num; sr_in = ~s; sp_in = sp + 32'h40; pc_in = ~pc;
    check(busy === 1'b1, "R8 busy after start", {31'b0, busy}, 1);
    if (inject) begin
      @(negedge clk);
      start = 1'b1; num = 4'(n + 5); sp_in = sp - 32'h20; // R9
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (done !== 1'b1 && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    check(done === 1'b1, "R8 done seen", {31'b0, done}, 1);
    check(sp_out === sp - 32'd6, "R6 sp_o", sp_out, sp - 32'd6);
    check(sr_out === (s | 16'h2000), "R5 sr_o", {16'b0, sr_out}, {16'b0, s | 16'h2000});
    check(pc_out === vec_word(n), "R2 pc_o", pc_out, vec_word(n));
    check(busy === 1'b1, "R8 busy in done cycle", {31'b0, busy}, 1);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R8 back to idle", {30'b0, done, busy}, 0);
    check(n_log == 5, "R7 access count R9", 32'(n_log), 5);
    check(log_we[0] === 1'b1 && log_addr[0] === sp - 4 && log_wd[0] === pc[31:16],
          "R3 pc high push", log_addr[0], sp - 4);
    check(log_we[1] === 1'b1 && log_addr[1] === sp - 2 && log_wd[1] === pc[15:0],
          "R3 pc low push", log_addr[1], sp - 2);
    check(log_we[2] === 1'b1 && log_addr[2] === sp - 6 && log_wd[2] === s,
          "R4 status push", {log_wd[2], log_addr[2][15:0]}, {s, sp[15:0] - 16'd6});
    check(log_we[3] === 1'b0 && log_addr[3] === va, "R2 vector high read", log_addr[3], va);
    check(log_we[4] === 1'b0 && log_addr[4] === va + 2, "R2 vector low read", log_addr[4], va + 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && req === 1'b0, "R1 reset handshake",
          {29'b0, busy, done, req}, 0);
    check(sr_out === '0 && sp_out === '0 && pc_out === '0, "R1 reset results", sp_out | pc_out, 0);
    rst_n = 1'b1;
    for (int l = 0; l < 3; l++) begin
      for (int n = 0; n < 16; n++) begin
        lat = l;
        run_trap(n, 16'h0700 ^ 16'(n * 16'h0111) ^ (n[0] ? 16'h2000 : 16'h0000),
                 32'd300 + 32'(n * 8) + 32'(l * 2), 32'h1234_0000 + 32'(n * 32'h0101_0013),
                 (l == 1) || (n == 15));
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R8 act=%h exp=%h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule